// File: doc/BRIEF.md
# Serial Configuration Loader

This block brings up a downstream FPGA over its slave-serial configuration pins, using an image that sits in a byte-wide memory. When `start_i` is pulsed, it fetches an 8-byte header and checks it. The header holds an identification word followed by the payload size, both most-significant byte first. If the header is accepted, the block resets the target by pulsing its active-low program pin and watching the init pin respond. It then streams the payload serially on a data line, using a clock that it divides down from the system clock. The loader keeps all-ones filler bytes flowing until the target reports completion, and then sends one closing byte.

The result is held on `done_o`, `err_o` and `err_code_o` until the next start. All waits are counted in system clock cycles. The cycle counts come from a clock-frequency parameter together with parameters for the wait times in microseconds or milliseconds. The target's init and done pins are asynchronous and pass through a synchronizer.

Top module: `fpga_cfg_loader`

## Requirements
- R1: Header bytes 0..3 form a big-endian word that must equal `MAGIC` (default 0x5352544D, byte 0 = 0x53). Any other value ends the run with error code 1. No configuration pin or output enable changes in that case.
- R2: Header bytes 4..7 form the big-endian payload length. A length above `MAX_LEN` (default 0x220000) ends the run with error code 2 and no pin change. A length equal to `MAX_LEN` is accepted.
- R3: After a valid header, CCLK, DIN and PROGRAM_B are all driven low with their enables on. PROGRAM_B stays low for at least `PROG_US` worth of cycles. INIT_B must then read low, otherwise the run ends with error code 3.
- R4: PROGRAM_B is then driven high and the block waits the full `INIT_US` interval. If INIT_B is then low, the run ends with error code 4. Otherwise, if DONE is high, the run ends with error code 5.
- R5: Payload byte k is read from address 8+k and shifted out MSB first. Each DIN value is set while CCLK is low and held while CCLK is high. PROGRAM_B stays driven high during shifting.
- R6: INIT_B is examined at the end of every payload byte. If it is low, the run ends with error code 6 and no further bytes are sent. This check wins over the hand-over to filler bytes on the last payload byte.
- R7: After the payload, 0xFF bytes are sent while DONE is low. Once DONE is seen high at a byte boundary, exactly one more 0xFF is sent. The CCLK and DIN enables then drop, PROGRAM_B stays driven high, and `done_o` is set with code 0.
- R8: If DONE has not been seen within `DONE_MS` worth of cycles from the end of the payload, the run ends with error code 7.
- R9: Each CCLK high phase and each low phase between bits lasts `max(1, CLK_HZ/(2*CCLK_HZ))` system cycles.
- R10: `busy_o` is high for the whole run. `done_o`, `err_o` and `err_code_o` clear at start and are then held until the next start. A start pulse while busy is ignored. After reset all outputs and enables are low.
- R11: Memory data is taken on the cycle after `mem_rd_o` is high with `mem_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run configured the target |
| err_o | output | 1 | Last run failed |
| err_code_o | output | 3 | Failure cause (0 none .. 7 DONE timeout) |
| mem_rd_o | output | 1 | Image read strobe |
| mem_addr_o | output | ADDR_W | Image byte address |
| mem_data_i | input | 8 | Image byte, one cycle after the strobe |
| cclk_o | output | 1 | Configuration clock |
| cclk_oe_o | output | 1 | Enable for cclk_o |
| din_o | output | 1 | Configuration data |
| din_oe_o | output | 1 | Enable for din_o |
| prog_b_o | output | 1 | Active-low program pin |
| prog_b_oe_o | output | 1 | Enable for prog_b_o |
| init_b_i | input | 1 | Target init pin, active low |
| done_i | input | 1 | Target done pin |

## Verification
At the end of the last payload byte, two things fall on the same boundary: the INIT_B abort check and the move to the filler phase. The bench provokes this by having its target model pull INIT_B low as that final byte completes. It expects code 6 and a count of received bytes equal to the payload length, with no filler seen. A second overlap is a start pulse that arrives during a run. The bench judges that case by requiring the byte stream and the final status to match an undisturbed run.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_MAGIC      = 3'd1,
    ERR_SIZE       = 3'd2,
    ERR_NO_INIT    = 3'd3,
    ERR_INIT_STUCK = 3'd4,
    ERR_DONE_EARLY = 3'd5,
    ERR_INIT_LOAD  = 3'd6,
    ERR_DONE_TMO   = 3'd7
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR_RD, S_HDR_CAP, S_HDR_CHK,
    S_PROG_LOW, S_INIT_WAIT,
    S_FETCH, S_LOAD_GO, S_LOAD_SH,
    S_FILL_CHK, S_FILL_SH, S_FINAL
  } st_e;

  localparam int unsigned HDR_BYTES = 8;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         exp_o
);

  logic [W-1:0] cnt_q;

  assign exp_o = (cnt_q >= lim_i);

  // saturates at the limit so a long stall cannot wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && !exp_o)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter #(
  parameter int unsigned HALF = 1,
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            start_i,
  input  logic [BITS-1:0] byte_i,
  output logic            cclk_o,
  output logic            din_o,
  output logic            done_o
);

  localparam int unsigned HC_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned BC_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF - 1);
  localparam logic [BC_W-1:0] BC_TOP  = BC_W'(BITS - 1);

  logic [BITS-1:0] sr_q;
  logic [BC_W-1:0] left_q;
  logic [HC_W-1:0] hc_q;
  logic            act_q, cclk_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
      hc_q   <= '0;
      act_q  <= 1'b0;
      cclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        sr_q   <= '0;
        act_q  <= 1'b0;
        cclk_q <= 1'b0;
        hc_q   <= '0;
      end else if (start_i) begin
        sr_q   <= byte_i;
        left_q <= BC_TOP;
        hc_q   <= '0;
        act_q  <= 1'b1;
        cclk_q <= 1'b0;
      end else if (act_q) begin
        if (hc_q == HC_LAST) begin
          hc_q <= '0;
          if (!cclk_q) begin
            cclk_q <= 1'b1;
          end else if (left_q == '0) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;        // CCLK parks high until the next byte
          end else begin
            cclk_q <= 1'b0;
            sr_q   <= {sr_q[BITS-2:0], 1'b0};
            left_q <= left_q - 1'b1;
          end
        end else begin
          hc_q <= hc_q + 1'b1;
        end
      end
    end
  end

  assign cclk_o = cclk_q;
  assign din_o  = sr_q[BITS-1];
  assign done_o = done_q;

  AST_DIN_STEADY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_o && $past(cclk_o)) |-> $stable(din_o)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfg_ld_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned CCLK_HZ     = 6_000_000,
  parameter int unsigned PROG_US     = 1000,
  parameter int unsigned INIT_US     = 10000,
  parameter int unsigned DONE_MS     = 100,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] MAGIC       = 32'h5352_544D,
  parameter logic [31:0] MAX_LEN     = 32'h0022_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_code_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              cclk_o,
  output logic              cclk_oe_o,
  output logic              din_o,
  output logic              din_oe_o,
  output logic              prog_b_o,
  output logic              prog_b_oe_o,
  input  logic              init_b_i,
  input  logic              done_i
);

  localparam int unsigned HALF_RAW = CLK_HZ / (2 * CCLK_HZ);
  localparam int unsigned HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int unsigned T_PROG   = 32'((64'(CLK_HZ) * 64'(PROG_US)) / 64'd1_000_000);
  localparam int unsigned T_INIT   = 32'((64'(CLK_HZ) * 64'(INIT_US)) / 64'd1_000_000);
  localparam int unsigned T_DONE   = 32'((64'(CLK_HZ) * 64'(DONE_MS)) / 64'd1_000);
  localparam int unsigned T_MAX    = max3(T_PROG, T_INIT, T_DONE);
  localparam int unsigned TMR_W    = $clog2(T_MAX + 1);
  localparam logic [2:0]  HDR_LAST = 3'(HDR_BYTES - 1);

  st_e         st_q;
  err_e        err_q;
  logic [63:0] hdr_q;
  logic [2:0]  hidx_q;
  logic [31:0] bcnt_q;
  logic        done_q, prog_q, prog_oe_q, data_oe_q;

  logic [31:0] magic_w, len_w;
  logic        init_s, done_s;
  logic        sh_start, sh_clr, sh_done, sh_cclk, sh_din;
  logic [7:0]  sh_byte;
  logic        tm_clr, tm_en, tm_exp;
  logic [TMR_W-1:0] tm_lim;

  assign magic_w = hdr_q[63:32];
  assign len_w   = hdr_q[31:0];

  cfg_pin_sync #(
    .STAGES (SYNC_STAGES),
    .W      (2),
    .RST_VAL(2'b10)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({init_b_i, done_i}),
    .q_o   ({init_s, done_s})
  );

  cfg_byte_shifter #(
    .HALF(HALF),
    .BITS(8)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sh_clr),
    .start_i(sh_start),
    .byte_i (sh_byte),
    .cclk_o (sh_cclk),
    .din_o  (sh_din),
    .done_o (sh_done)
  );

  cfg_wait_timer #(
    .W(TMR_W)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tm_clr),
    .en_i  (tm_en),
    .lim_i (tm_lim),
    .exp_o (tm_exp)
  );

  always_comb begin
    sh_clr   = (st_q == S_HDR_CHK);
    sh_start = (st_q == S_LOAD_GO) ||
               ((st_q == S_FILL_CHK) && (done_s || !tm_exp));
    sh_byte  = (st_q == S_LOAD_GO) ? mem_data_i : 8'hFF;
    tm_en    = (st_q inside {S_PROG_LOW, S_INIT_WAIT, S_FILL_CHK, S_FILL_SH});
    tm_clr   = (st_q == S_HDR_CHK) ||
               ((st_q == S_PROG_LOW)  && tm_exp) ||
               ((st_q == S_INIT_WAIT) && tm_exp) ||
               ((st_q == S_LOAD_SH)   && sh_done);
    unique case (st_q)
      S_PROG_LOW:  tm_lim = TMR_W'(T_PROG);
      S_INIT_WAIT: tm_lim = TMR_W'(T_INIT);
      default:     tm_lim = TMR_W'(T_DONE);
    endcase
    mem_rd_o   = (st_q == S_HDR_RD) || (st_q == S_FETCH);
    mem_addr_o = (st_q == S_HDR_RD) ? ADDR_W'(hidx_q)
                                    : ADDR_W'(bcnt_q + 32'(HDR_BYTES));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      err_q     <= ERR_NONE;
      hdr_q     <= '0;
      hidx_q    <= '0;
      bcnt_q    <= '0;
      done_q    <= 1'b0;
      prog_q    <= 1'b0;
      prog_oe_q <= 1'b0;
      data_oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          err_q  <= ERR_NONE;
          done_q <= 1'b0;
          hidx_q <= '0;
          st_q   <= S_HDR_RD;
        end
        S_HDR_RD: st_q <= S_HDR_CAP;
        S_HDR_CAP: begin
          hdr_q <= {hdr_q[55:0], mem_data_i};
          if (hidx_q == HDR_LAST) st_q <= S_HDR_CHK;
          else begin
            hidx_q <= hidx_q + 1'b1;
            st_q   <= S_HDR_RD;
          end
        end
        S_HDR_CHK: begin
          if (magic_w != MAGIC) begin
            err_q <= ERR_MAGIC;
            st_q  <= S_IDLE;
          end else if (len_w > MAX_LEN) begin
            err_q <= ERR_SIZE;
            st_q  <= S_IDLE;
          end else begin
            prog_q    <= 1'b0;
            prog_oe_q <= 1'b1;
            data_oe_q <= 1'b1;
            st_q      <= S_PROG_LOW;
          end
        end
        S_PROG_LOW: if (tm_exp) begin
          if (init_s) begin
            err_q     <= ERR_NO_INIT;
            data_oe_q <= 1'b0;
            st_q      <= S_IDLE;
          end else begin
            prog_q <= 1'b1;
            st_q   <= S_INIT_WAIT;
          end
        end
        S_INIT_WAIT: if (tm_exp) begin
          bcnt_q <= '0;
          if (!init_s) begin
            err_q     <= ERR_INIT_STUCK;
            data_oe_q <= 1'b0;
            st_q      <= S_IDLE;
          end else if (done_s) begin
            err_q     <= ERR_DONE_EARLY;
            data_oe_q <= 1'b0;
            st_q      <= S_IDLE;
          end else begin
            st_q <= (len_w == '0) ? S_FILL_CHK : S_FETCH;
          end
        end
        S_FETCH:   st_q <= S_LOAD_GO;
        S_LOAD_GO: st_q <= S_LOAD_SH;
        S_LOAD_SH: if (sh_done) begin
          bcnt_q <= bcnt_q + 1'b1;
          // abort check wins over the hand-over to filler bytes
          if (!init_s) begin
            err_q     <= ERR_INIT_LOAD;
            data_oe_q <= 1'b0;
            st_q      <= S_IDLE;
          end else if (bcnt_q + 32'd1 == len_w) begin
            st_q <= S_FILL_CHK;
          end else begin
            st_q <= S_FETCH;
          end
        end
        S_FILL_CHK: begin
          if (done_s)       st_q <= S_FINAL;
          else if (tm_exp) begin
            err_q     <= ERR_DONE_TMO;
            data_oe_q <= 1'b0;
            st_q      <= S_IDLE;
          end else          st_q <= S_FILL_SH;
        end
        S_FILL_SH: if (sh_done) st_q <= S_FILL_CHK;
        S_FINAL: if (sh_done) begin
          data_oe_q <= 1'b0;
          done_q    <= 1'b1;
          st_q      <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = (err_q != ERR_NONE);
  assign err_code_o  = err_q;
  assign cclk_o      = sh_cclk;
  assign din_o       = sh_din;
  assign cclk_oe_o   = data_oe_q;
  assign din_oe_o    = data_oe_q;
  assign prog_b_o    = prog_q;
  assign prog_b_oe_o = prog_oe_q;

  AST_PINS_QUIET_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {S_HDR_RD, S_HDR_CAP}) |=>
      $stable({prog_b_o, prog_b_oe_o, cclk_oe_o, din_oe_o})); // R1

  AST_DRIVE_IN_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PROG_LOW) |->
      (!prog_b_o && prog_b_oe_o && cclk_oe_o && din_oe_o && !cclk_o && !din_o)); // R3

  AST_PROG_HIGH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {S_FETCH, S_LOAD_GO, S_LOAD_SH, S_FILL_CHK, S_FILL_SH, S_FINAL}) |->
      (prog_b_o && prog_b_oe_o)); // R5

  AST_BUSY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!done_o && !err_o)); // R10

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(err_code_o) && $stable(done_o))); // R10

endmodule

// File: tb/tb_fpga_cfg_loader.sv
`timescale 1ns/1ps
module tb_fpga_cfg_loader;

  localparam int unsigned CLK_HZ  = 100_000;
  localparam int unsigned CCLK_HZ = 25_000;
  localparam int HALF   = 2;
  localparam int T_PROG = 100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start;
  logic        busy, done, err, mem_rd;
  logic [2:0]  code;
  logic [31:0] addr;
  logic [7:0]  mem_data;
  logic        cclk, cclk_oe, din, din_oe, prog_b, prog_oe;
  logic        init_b, done_in;

  fpga_cfg_loader #(
    .CLK_HZ (CLK_HZ),
    .CCLK_HZ(CCLK_HZ)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(code),
    .mem_rd_o(mem_rd), .mem_addr_o(addr), .mem_data_i(mem_data),
    .cclk_o(cclk), .cclk_oe_o(cclk_oe), .din_o(din), .din_oe_o(din_oe),
    .prog_b_o(prog_b), .prog_b_oe_o(prog_oe),
    .init_b_i(init_b), .done_i(done_in)
  );

  int nvec = 0, nerr = 0;
  logic [7:0] img [0:63];
  logic [7:0] cap [0:127];
  int  cfg_len, cfg_fill, cfg_drop;
  bit  cfg_no_init, cfg_stuck, cfg_early, mdl_clear;
  int  ncap, nbits, rel_cnt, prog_low_cyc, run_len, min_hi, min_lo;
  bit  released, pin_moved, prog_drive_ok;
  logic [7:0] shreg;
  logic cclk_prev;
  logic [3:0] pins_prev;

  // memory with one cycle of read latency, and a model of the target pins
  always @(negedge clk) begin
    if (mem_rd) mem_data <= img[addr[5:0]];
    if (!rst_n || mdl_clear) begin
      init_b <= 1'b1; done_in <= 1'b0;
      ncap = 0; nbits = 0; rel_cnt = 0; prog_low_cyc = 0; released = 0;
      pin_moved = 0; prog_drive_ok = 1; run_len = 0; min_hi = 1000; min_lo = 1000;
      cclk_prev = cclk; pins_prev = {prog_b, prog_oe, cclk_oe, din_oe};
    end else begin
      if ({prog_b, prog_oe, cclk_oe, din_oe} != pins_prev) pin_moved = 1;
      pins_prev = {prog_b, prog_oe, cclk_oe, din_oe};
      if (prog_oe && !prog_b) begin
        prog_low_cyc++;
        if (!(cclk_oe && din_oe && !cclk && !din)) prog_drive_ok = 0;
        released = 0; rel_cnt = 0;
        init_b <= cfg_no_init;
      end else if (prog_oe && prog_b && prog_low_cyc > 0 && !released) begin
        rel_cnt++;
        if (rel_cnt == 20) begin released = 1; init_b <= !cfg_stuck; end
      end
      if (cclk_oe) begin
        if (cclk == cclk_prev) run_len++;
        else begin
          if (run_len > 0) begin
            if (cclk_prev) begin if (run_len < min_hi) min_hi = run_len; end
            else           begin if (run_len < min_lo) min_lo = run_len; end
          end
          run_len = 1;
        end
        if (cclk && !cclk_prev) begin
          shreg = {shreg[6:0], din};
          nbits++;
          if (nbits == 8) begin
            if (ncap < 128) cap[ncap] = shreg;
            ncap++; nbits = 0;
            if (ncap - 1 == cfg_drop) init_b <= 1'b0;
          end
        end
      end
      cclk_prev = cclk;
      done_in <= cfg_early ? 1'b1 :
                 (cfg_fill >= 0 && released && ncap > 0 && ncap >= cfg_len + cfg_fill);
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] mg, input logic [31:0] lenf, input int plen,
                       input int fill, input int drop, input bit ni, input bit stk, input bit ea);
    @(posedge clk);
    {img[0], img[1], img[2], img[3]} = mg;
    {img[4], img[5], img[6], img[7]} = lenf;
    for (int i = 0; i < plen; i++) img[8+i] = 8'($urandom);
    cfg_len = plen; cfg_fill = fill; cfg_drop = drop;
    cfg_no_init = ni; cfg_stuck = stk; cfg_early = ea;
    mdl_clear = 1;
    @(posedge clk);
    mdl_clear = 0;
  endtask

  task automatic run(input bit restart);
    @(negedge clk) start = 1;
    for (int cyc = 0; cyc < 40000; cyc++) begin
      @(negedge clk);
      start = (restart && cyc == 200);
      if (cyc > 0 && !busy) break;
    end
    start = 0;
  endtask

  task automatic expect_err(input int ec, input string tag);
    chk(code == 3'(ec), tag, code, ec);
    chk(err && !done && !busy, tag, {err, done, busy}, 3'b100);
  endtask

  task automatic good_run(input int plen, input int fill, input bit restart);
    setup(32'h5352544D, 32'(plen), plen, fill, -1, 0, 0, 0);
    run(restart);
    chk(code == 3'd0 && done && !err, "R7 status", {code, done, err}, 5'b00010);
    chk(ncap == plen + fill + 1, "R7 byte count", ncap, plen + fill + 1);
    for (int i = 0; i < plen; i++)
      if (cap[i] != img[8+i]) chk(0, "R5 payload byte", cap[i], img[8+i]);
    for (int i = plen; i < ncap && i < 128; i++)
      if (cap[i] != 8'hFF) chk(0, "R7 filler byte", cap[i], 8'hFF);
    chk(!cclk_oe && !din_oe && prog_oe && prog_b, "R7 pins released",
        {cclk_oe, din_oe, prog_oe, prog_b}, 4'b0011);
    chk(prog_low_cyc >= T_PROG && prog_drive_ok, "R3 program pulse", prog_low_cyc, T_PROG);
    chk(min_hi == HALF && min_lo == HALF, "R9 half period", {min_hi[15:0], min_lo[15:0]},
        {16'(HALF), 16'(HALF)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; start = 0; mdl_clear = 0;
    cfg_len = 0; cfg_fill = 0; cfg_drop = -1;
    cfg_no_init = 0; cfg_stuck = 0; cfg_early = 0;
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !err && code == 0 && !mem_rd, "R10 reset outputs",
        {busy, done, err, code, mem_rd}, 0);
    chk(!cclk_oe && !din_oe && !prog_oe, "R10 reset enables", {cclk_oe, din_oe, prog_oe}, 0);

    setup(32'h5352544E, 32'd4, 4, 1, -1, 0, 0, 0);
    run(0);
    expect_err(1, "R1 bad magic");
    chk(!pin_moved, "R1 no pin change", pin_moved, 0);

    setup(32'h5352544D, 32'h0022_0001, 0, 1, -1, 0, 0, 0);
    run(0);
    expect_err(2, "R2 too large");
    chk(!pin_moved, "R2 no pin change", pin_moved, 0);

    // maximum length passes the size check and reaches the program pulse
    setup(32'h5352544D, 32'h0022_0000, 0, 1, -1, 1, 0, 0);
    run(0);
    expect_err(3, "R2/R3 no init on program");

    setup(32'h5352544D, 32'd4, 4, 1, -1, 0, 1, 0);
    run(0);
    expect_err(4, "R4 init stuck low");

    setup(32'h5352544D, 32'd4, 4, 1, -1, 0, 0, 1);
    run(0);
    expect_err(5, "R4 done early");

    setup(32'h5352544D, 32'd10, 10, 1, 2, 0, 0, 0);
    run(0);
    expect_err(6, "R6 init during load");
    chk(ncap == 3, "R6 bytes before abort", ncap, 3);

    // INIT drops on the last payload byte: abort beats filler hand-over
    setup(32'h5352544D, 32'd5, 5, 1, 4, 0, 0, 0);
    run(0);
    expect_err(6, "R6 abort on last byte");
    chk(ncap == 5, "R6 no filler after abort", ncap, 5);

    setup(32'h5352544D, 32'd3, 3, -1, -1, 0, 0, 0);
    run(0);
    expect_err(7, "R8 done timeout");
    chk(ncap > 3, "R8 filler sent before timeout", ncap, 4);
    chk(!cclk_oe && !din_oe, "R8 data pins released", {cclk_oe, din_oe}, 0);

    good_run(6, 0, 0);   // R7 done right after payload
    good_run(0, 2, 0);   // R7 empty payload
    good_run(8, 1, 1);   // R10 start while busy ignored
    repeat (40) @(negedge clk);
    chk(done && code == 0, "R10 result held", {done, code}, 4'b1000);

    for (int t = 0; t < 10; t++) begin
      int pl, fl;
      pl = 1 + int'($urandom_range(39));
      fl = 1 + int'($urandom_range(2));
      good_run(pl, fl, 0);  // R5 R11 random payloads
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule